// File: doc/BRIEF.md
# Parallel camera pixel capture

This block takes bytes from an external image sensor, which clocks them out on its own pixel clock, and delivers them as packed words in the system clock domain. On each rising edge of the pixel clock a byte is qualified: either both data-enable lines must be high, or the block is told to ignore the enables. An optional decimator keeps only every other qualified byte, for example to keep only luminance from an interleaved stream. Kept bytes are packed into 8, 16 or 32 bit words. Each finished word crosses into the system domain through a toggle handshake and lands in a single holding register.

The output is a valid/ready stream with no back-pressure towards the sensor. The sensor cannot be stalled, so the block is lossy. A word stays in the holding register and `out_valid` stays high until the consumer accepts it with `out_ready` high. If a newer word arrives first, it replaces the held word and `overrun` is raised. The configuration inputs are quasi-static: they change only while capture is disabled or while the pixel clock is idle. The pixel clock must run at no more than half the system clock.

Top module: `pixcap_top`

## Requirements
- R1: After reset, `out_valid` and `overrun` are 0 and `out_data` is 0.
- R2: While `cap_en` is 0, no bytes are captured and no word is delivered, whatever the data enables and mode inputs do.
- R3: With `ign_de` = 0, a byte is qualified on a rising `cam_clk` edge only when `cam_de_a` and `cam_de_b` are both 1.
- R4: With `ign_de` = 1, a byte is qualified on every rising `cam_clk` edge while capture is enabled.
- R5: `size_sel` selects the word size: 0 = one byte, 1 = two bytes, 2 or 3 = four bytes. The first kept byte lands in bits [7:0] and later bytes fill higher lanes. Bits above the selected size read 0.
- R6: With `half_rate` = 1, the first qualified byte after capture is enabled is kept, the next is dropped, and keeping alternates from there. Disabling capture restarts this pattern and discards any partly packed word.
- R7: When a word completes, it appears on `out_data` with `out_valid` = 1 within four system clock cycles of the completing `cam_clk` edge.
- R8: A cycle with `out_valid` and `out_ready` both 1 accepts the word. `out_valid` then falls unless a new word arrives in the same cycle.
- R9: A word that arrives while an unaccepted word is held overwrites it and sets `overrun`. `overrun` is cleared by the next accept and is never 1 while `out_valid` is 0.
- R10: While `out_valid` = 1 and no accept or new word occurs, `out_data` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset for both domains |
| cam_clk | input | 1 | Sensor pixel clock |
| cam_data | input | 8 | Sensor pixel byte, valid at rising `cam_clk` |
| cam_de_a | input | 1 | First sensor data enable |
| cam_de_b | input | 1 | Second sensor data enable |
| cap_en | input | 1 | Capture enable, synchronized into the pixel clock domain |
| size_sel | input | 2 | Word size: 0 = 8, 1 = 16, 2/3 = 32 bits |
| ign_de | input | 1 | 1 = qualify every edge and ignore the enables |
| half_rate | input | 1 | 1 = keep every other qualified byte |
| out_data | output | 32 | Held packed word |
| out_valid | output | 1 | Held word is unread |
| out_ready | input | 1 | Consumer accepts the held word |
| overrun | output | 1 | A held word was overwritten before being read |

## Verification
A wrong lane counter or wrong decimator phase corrupts the first word after it goes wrong. That word is delivered within four system cycles of its last byte, with bytes in the wrong lanes or a byte missing. A wrong toggle or slot selection in the crossing shows up as a stale or duplicated word on the next delivery. Errors in the valid or overrun logic appear in the cycle after an accept or an arrival, through `out_valid`, `overrun` or a moving `out_data`.

// File: rtl/pixcap_pkg.sv
package pixcap_pkg;
  localparam int PIX_BYTE_W = 8;
  localparam int SYNC_DEPTH = 2;

  typedef enum logic [1:0] {
    SZ_ONE  = 2'd0,
    SZ_TWO  = 2'd1,
    SZ_FOUR = 2'd2,
    SZ_WIDE = 2'd3
  } pack_size_e;
endpackage

// File: rtl/pixcap_sync.sv
module pixcap_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[g] <= '0;
        else        stg[g] <= d;
      end
    end else begin : g_rest
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[g] <= '0;
        else        stg[g] <= stg[g-1];
      end
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/pixcap_front.sv
module pixcap_front #(
  parameter int WORD_W = 32,
  parameter int BYTE_W = 8
) (
  input  logic                   cam_clk,
  input  logic                   rst_n,
  input  logic                   en_s,
  input  logic [BYTE_W-1:0]      cam_data,
  input  logic                   cam_de_a,
  input  logic                   cam_de_b,
  input  logic [1:0]             size_sel,
  input  logic                   ign_de,
  input  logic                   half_rate,
  output logic [1:0][WORD_W-1:0] slot_q,
  output logic                   tog_q
);
  localparam int LANES    = WORD_W / BYTE_W;
  localparam int LANE_W   = (LANES > 1) ? $clog2(LANES) : 1;
  localparam int SIZE_LOG = (LANES > 1) ? $clog2(LANES) : 0;

  logic [LANE_W-1:0] lane_cnt;
  logic [LANE_W-1:0] last_lane;
  logic [WORD_W-1:0] acc;
  logic [WORD_W-1:0] merged;
  logic              skip_ph;
  logic              qual;
  logic              keep;

  always_comb begin
    if (int'(size_sel) >= SIZE_LOG) last_lane = LANE_W'(LANES - 1);
    else                            last_lane = LANE_W'((1 << size_sel) - 1);
  end

  assign qual   = ign_de | (cam_de_a & cam_de_b);
  assign keep   = qual & ~(half_rate & skip_ph);
  assign merged = acc | (WORD_W'(cam_data) << (BYTE_W * int'(lane_cnt)));

  always_ff @(posedge cam_clk or negedge rst_n) begin
    if (!rst_n) begin
      lane_cnt <= '0;
      acc      <= '0;
      skip_ph  <= 1'b0;
      tog_q    <= 1'b0;
      slot_q   <= '0;
    end else if (!en_s) begin
      lane_cnt <= '0;
      acc      <= '0;
      skip_ph  <= 1'b0;
    end else if (qual) begin
      if (half_rate) skip_ph <= ~skip_ph;
      if (keep) begin
        if (lane_cnt == last_lane) begin
          slot_q[~tog_q] <= merged;
          tog_q          <= ~tog_q;
          acc            <= '0;
          lane_cnt       <= '0;
        end else begin
          acc      <= merged;
          lane_cnt <= lane_cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pixcap_hold.sv
module pixcap_hold #(
  parameter int WORD_W = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   tog_s,
  input  logic [1:0][WORD_W-1:0] slot_q,
  input  logic                   out_ready,
  output logic [WORD_W-1:0]      out_data,
  output logic                   out_valid,
  output logic                   overrun,
  output logic                   load
);
  logic tog_prev;
  logic accept;

  assign load   = tog_s ^ tog_prev;
  assign accept = out_valid & out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tog_prev  <= 1'b0;
      out_data  <= '0;
      out_valid <= 1'b0;
      overrun   <= 1'b0;
    end else begin
      tog_prev <= tog_s;
      if (load) begin
        out_data  <= slot_q[tog_s];
        out_valid <= 1'b1;
        overrun   <= out_valid & ~out_ready;
      end else if (accept) begin
        out_valid <= 1'b0;
        overrun   <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pixcap_top.sv
module pixcap_top #(
  parameter int WORD_W = 32,
  parameter int BYTE_W = pixcap_pkg::PIX_BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cam_clk,
  input  logic [BYTE_W-1:0] cam_data,
  input  logic              cam_de_a,
  input  logic              cam_de_b,
  input  logic              cap_en,
  input  logic [1:0]        size_sel,
  input  logic              ign_de,
  input  logic              half_rate,
  output logic [WORD_W-1:0] out_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              overrun
);
  logic                   en_s;
  logic                   tog_q;
  logic                   tog_s;
  logic                   word_load;
  logic [1:0][WORD_W-1:0] slot_q;

  pixcap_sync #(.W(1), .STAGES(pixcap_pkg::SYNC_DEPTH)) u_en_sync (
    .clk(cam_clk), .rst_n(rst_n), .d(cap_en), .q(en_s)
  );

  pixcap_front #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) u_front (
    .cam_clk(cam_clk), .rst_n(rst_n), .en_s(en_s),
    .cam_data(cam_data), .cam_de_a(cam_de_a), .cam_de_b(cam_de_b),
    .size_sel(size_sel), .ign_de(ign_de), .half_rate(half_rate),
    .slot_q(slot_q), .tog_q(tog_q)
  );

  pixcap_sync #(.W(1), .STAGES(pixcap_pkg::SYNC_DEPTH)) u_tog_sync (
    .clk(clk), .rst_n(rst_n), .d(tog_q), .q(tog_s)
  );

  pixcap_hold #(.WORD_W(WORD_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .tog_s(tog_s), .slot_q(slot_q),
    .out_ready(out_ready), .out_data(out_data), .out_valid(out_valid),
    .overrun(overrun), .load(word_load)
  );
endmodule

// File: rtl/pixcap_checker.sv
module pixcap_checker #(
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [WORD_W-1:0] out_data,
  input logic              out_valid,
  input logic              out_ready,
  input logic              overrun,
  input logic              load
);
  a_r7_load_sets_valid: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> out_valid);

  a_r8_fall_needs_accept: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_valid) |-> $past(out_ready));

  a_r8_accept_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !load) |=> !out_valid);

  a_r9_overrun_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |-> out_valid);

  a_r9_overrun_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> $past(out_valid && !out_ready));

  a_r10_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !load) |=> (out_valid && $stable(out_data)));
endmodule

bind pixcap_top pixcap_checker #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .out_data(out_data), .out_valid(out_valid),
  .out_ready(out_ready), .overrun(overrun), .load(word_load)
);

// File: tb/pixcap_top_bench.sv
module pixcap_top_bench;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cam_clk = 1'b0;
  logic [7:0]  cam_data = '0;
  logic        cam_de_a = 1'b0, cam_de_b = 1'b0;
  logic        cap_en = 1'b0;
  logic [1:0]  size_sel = '0;
  logic        ign_de = 1'b0, half_rate = 1'b0;
  logic [31:0] out_data;
  logic        out_valid, out_ready = 1'b1, overrun;

  int checks = 0, errors = 0;
  bit auto_rx = 1'b1;
  bit model_on = 1'b1;
  int rx_cnt = 0;
  logic [31:0] last_rx = '0;
  logic [31:0] exp_q[$];

  // reference packer state
  bit m_ph;
  int m_cnt;
  logic [31:0] m_acc;

  always #(CLK_P/2) clk = ~clk;

  pixcap_top u_pixcap_top (
    .clk(clk), .rst_n(rst_n), .cam_clk(cam_clk), .cam_data(cam_data),
    .cam_de_a(cam_de_a), .cam_de_b(cam_de_b), .cap_en(cap_en),
    .size_sel(size_sel), .ign_de(ign_de), .half_rate(half_rate),
    .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready),
    .overrun(overrun)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int lanes_of(input logic [1:0] s);
    return (s == 2'd0) ? 1 : (s == 2'd1) ? 2 : 4;
  endfunction

  task automatic model_beat(input logic [7:0] d, input bit a, input bit b);
    bit keep;
    if (!(model_on && cap_en)) return;
    if (!(ign_de || (a && b))) return;
    keep = !(half_rate && m_ph);
    if (half_rate) m_ph = !m_ph;
    if (!keep) return;
    m_acc = m_acc | (32'(d) << (8 * m_cnt));
    if (m_cnt == lanes_of(size_sel) - 1) begin
      exp_q.push_back(m_acc);
      m_acc = '0;
      m_cnt = 0;
    end else m_cnt++;
  endtask

  task automatic beat(input logic [7:0] d, input bit a, input bit b);
    cam_data = d; cam_de_a = a; cam_de_b = b;
    model_beat(d, a, b);
    #(2*CLK_P) cam_clk = 1'b1;
    #(2*CLK_P) cam_clk = 1'b0;
  endtask

  task automatic start_cfg(input logic [1:0] s, input bit ign, input bit half);
    ign_de = 1'b0;
    cap_en = 1'b0;
    repeat (4) beat(8'h00, 1'b0, 1'b0);
    size_sel = s; half_rate = half;
    m_ph = 1'b0; m_cnt = 0; m_acc = '0;
    cap_en = 1'b1;
    repeat (4) beat(8'h00, 1'b0, 1'b0);
    ign_de = ign;
  endtask

  // consumer with ready held high
  always @(negedge clk) begin
    if (rst_n && auto_rx && out_valid && out_ready) begin
      if (exp_q.size() == 0) check(1'b0, "R2 unexpected word", out_data, 32'h0);
      else begin
        logic [31:0] e;
        e = exp_q.pop_front();
        check(out_data == e, "R5 word content", out_data, e);
      end
      rx_cnt++;
      last_rx = out_data;
    end
  end

  initial begin
    #(CLK_P*150000);
    check(1'b0, "watchdog", 32'h0, 32'h0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int base;
    void'($urandom(32'd24681));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(out_valid == 1'b0, "R1 valid", 32'(out_valid), 32'h0);
    check(overrun == 1'b0, "R1 overrun", 32'(overrun), 32'h0);
    check(out_data == 32'h0, "R1 data", out_data, 32'h0);

    // R3 both enables needed
    start_cfg(2'd0, 1'b0, 1'b0);
    base = rx_cnt;
    beat(8'h11, 1'b1, 1'b0); beat(8'h22, 1'b0, 1'b1);
    beat(8'h5C, 1'b1, 1'b1); beat(8'h33, 1'b0, 1'b0);
    repeat (10) @(negedge clk);
    check(rx_cnt - base == 1, "R3 one qualified byte", 32'(rx_cnt - base), 32'd1);
    check(last_rx == 32'h5C, "R3 byte value", last_rx, 32'h5C);

    // R4 ignore enables, R5 sizes
    start_cfg(2'd2, 1'b1, 1'b0);
    beat(8'h01, 1'b0, 1'b0); beat(8'h02, 1'b1, 1'b0);
    beat(8'h03, 1'b0, 1'b1); beat(8'h04, 1'b0, 1'b0);
    repeat (10) @(negedge clk);
    check(last_rx == 32'h04030201, "R4 R5 32-bit lanes", last_rx, 32'h04030201);
    start_cfg(2'd1, 1'b1, 1'b0);
    beat(8'hA5, 1'b0, 1'b0); beat(8'h5A, 1'b0, 1'b0);
    repeat (10) @(negedge clk);
    check(last_rx == 32'h00005AA5, "R5 16-bit upper zero", last_rx, 32'h00005AA5);
    start_cfg(2'd3, 1'b1, 1'b0);
    beat(8'hDE, 1'b0, 1'b0); beat(8'hAD, 1'b0, 1'b0);
    beat(8'hBE, 1'b0, 1'b0); beat(8'hEF, 1'b0, 1'b0);
    repeat (10) @(negedge clk);
    check(last_rx == 32'hEFBEADDE, "R5 code 3 is 32-bit", last_rx, 32'hEFBEADDE);

    // R6 half-rate with restart on disable
    start_cfg(2'd1, 1'b1, 1'b1);
    beat(8'h11, 0, 0); beat(8'h22, 0, 0); beat(8'h33, 0, 0);
    beat(8'h44, 0, 0); beat(8'h55, 0, 0);
    repeat (10) @(negedge clk);
    check(last_rx == 32'h3311, "R6 keep alternate", last_rx, 32'h3311);
    start_cfg(2'd1, 1'b1, 1'b1);
    beat(8'h66, 0, 0); beat(8'h77, 0, 0); beat(8'h88, 0, 0);
    repeat (10) @(negedge clk);
    check(last_rx == 32'h8866, "R6 restart after disable", last_rx, 32'h8866);

    // R2 disabled capture
    start_cfg(2'd0, 1'b0, 1'b0);
    cap_en = 1'b0;
    repeat (4) beat(8'h00, 1'b0, 1'b0);
    ign_de = 1'b1;
    base = rx_cnt;
    repeat (6) beat(8'h9F, 1'b1, 1'b1);
    repeat (10) @(negedge clk);
    check(rx_cnt == base, "R2 no word while disabled", 32'(rx_cnt - base), 32'h0);
    check(out_valid == 1'b0, "R2 valid low", 32'(out_valid), 32'h0);

    // R7..R10 overrun and hold
    start_cfg(2'd0, 1'b0, 1'b0);
    auto_rx = 1'b0; model_on = 1'b0; out_ready = 1'b0;
    ign_de = 1'b1;
    beat(8'hA1, 0, 0);
    repeat (4) @(negedge clk);
    check(out_valid == 1'b1 && out_data == 32'hA1, "R7 word delivered", out_data, 32'hA1);
    beat(8'hB2, 0, 0);
    ign_de = 1'b0;
    repeat (8) @(negedge clk);
    check(out_valid == 1'b1, "R9 valid held", 32'(out_valid), 32'h1);
    check(out_data == 32'hB2, "R9 overwritten", out_data, 32'hB2);
    check(overrun == 1'b1, "R9 overrun set", 32'(overrun), 32'h1);
    repeat (5) @(negedge clk);
    check(out_data == 32'hB2 && out_valid, "R10 stable", out_data, 32'hB2);
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    check(out_valid == 1'b0, "R8 accept clears valid", 32'(out_valid), 32'h0);
    check(overrun == 1'b0, "R9 accept clears overrun", 32'(overrun), 32'h0);
    out_ready = 1'b1; auto_rx = 1'b1; model_on = 1'b1;

    // random episodes
    for (int ep = 0; ep < 40; ep++) begin
      logic [1:0] s;
      bit ig, hf;
      int n, pa;
      s  = 2'($urandom_range(0, 3));
      ig = 1'($urandom_range(0, 1));
      hf = 1'($urandom_range(0, 1));
      n  = $urandom_range(5, 40);
      pa = $urandom_range(30, 90);
      start_cfg(s, ig, hf);
      for (int k = 0; k < n; k++)
        beat(8'($urandom), ($urandom_range(0, 99) < pa), ($urandom_range(0, 99) < pa));
      repeat (10) @(negedge clk);
      check(exp_q.size() == 0, ig ? "R4 R6 all words delivered" : "R3 R6 all words delivered",
            32'(exp_q.size()), 32'h0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule